// File: doc/BRIEF.md
# One-time-programmable protection register pair

This block holds two 64-bit protection registers built from fuse-like storage. The first carries a unique identifier that is fixed when the chip is made, and no user operation can alter it. The second is a user segment. It starts fully erased with every bit at 1. Software may clear bits in it but can never set them again. A one-time lock bit can then freeze the user segment for good.

Both registers are read as 16-bit words through a registered, word-addressed read port. A status word at the address just past the two registers shows the lock state. Programming goes through a single command port that names a word and supplies data. The stored value becomes the bitwise AND of the old word and the new data. Each command ends with a one-cycle pulse of either `prog_done` or `prot_err`.

`rst_n` clears only the read and command outputs, and the fuse contents and the lock survive it. Only `mfg_init` models the manufacture step. It reloads the identifier, erases the user segment and clears the lock.

Top module: `otp_prot_regs`

## Requirements
- R1: Read addresses 0 to 3 return the factory identifier FACTORY_ID, with address 0 giving bits 15:0 and address 3 giving bits 63:48.
- R2: A program command with `prog_sel`=0 (factory register) leaves the factory register unchanged and pulses `prot_err`, not `prog_done`, in the cycle after the command.
- R3: Read addresses 4 to 7 return user words 0 to 3, and every user bit reads 1 after `mfg_init`.
- R4: A program command with `prog_sel`=1 on an unlocked user segment replaces the addressed word with (old AND `prog_data`), leaves the other words alone, and pulses `prog_done` in the next cycle.
- R5: `lock_req` on an unlocked segment sets the lock and pulses `prog_done`. The status word at address 8 has bit 0 always 1, bit 1 equal to the user lock, and all other bits 0.
- R6: Once locked, the lock cannot be cleared by any command. A user program is refused and leaves the contents unchanged, and a repeated `lock_req` is refused. Each refusal pulses `prot_err`.
- R7: The user contents and the lock survive `rst_n`. A cycle with `mfg_init` high reloads FACTORY_ID, sets all user bits to 1, clears the lock, and ignores any command given in that cycle.
- R8: If `prog_en` and `lock_req` arrive in the same cycle, the program is judged against the lock state from before that cycle, and the lock is set afterwards.
- R9: `rd_en` gives `rd_data` and a one-cycle `rd_valid` in the next cycle. Addresses 9 to 15 read 0, and `rd_data` holds its value between reads. Reset clears `rd_data`, `rd_valid`, `prog_done` and `prot_err` to 0.
- R10: `prog_done` and `prot_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the port registers only |
| mfg_init | input | 1 | Manufacture-time initialisation of the fuse state |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Word address: 0-3 factory, 4-7 user, 8 status |
| rd_data | output | 16 | Read word, registered |
| rd_valid | output | 1 | rd_data was loaded this cycle |
| prog_en | input | 1 | Program command strobe |
| prog_sel | input | 1 | Target register: 0 factory, 1 user |
| prog_word | input | 2 | Word index inside the target register |
| prog_data | input | 16 | Program data, ANDed into the stored word |
| lock_req | input | 1 | Request to set the user lock |
| prog_done | output | 1 | Command accepted, one-cycle pulse |
| prot_err | output | 1 | Command refused, one-cycle pulse |

## Verification
The assertions run on every cycle. They check that the identifier never moves outside `mfg_init` and that user bits only ever fall. They also check that the lock never drops once set, that a locked segment stays frozen, that a factory program always raises the error flag, that a read always gives `rd_valid`, and that `prog_done` and `prot_err` are never high together. Only the bench scenarios can show the actual values involved. These are the stored AND results, the address-to-word order, the status word encoding, the same-cycle program-and-lock ordering, and the fact that fuse state survives `rst_n` but not `mfg_init`.

// File: rtl/otp_pkg.sv
package otp_pkg;

    // Target of a program command.
    typedef enum logic {
        SEL_FACTORY = 1'b0,
        SEL_USER    = 1'b1
    } otp_sel_e;

    // Outcome of one command cycle.
    typedef struct packed {
        logic accept;
        logic refuse;
    } verdict_t;

endpackage

// File: rtl/otp_word_bank.sv
module otp_word_bank #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 4,
    parameter logic [WORD_W*WORDS-1:0] INIT = '1,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    init,
    input  logic                    wr_en,
    input  logic [WSEL_W-1:0]       wr_word,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORD_W*WORDS-1:0] bits
);

    // One fuse word per slot; a write can only clear bits.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_d;
        logic [WORD_W-1:0] word_q;

        always_comb begin
            word_d = word_q;
            if (init) begin
                word_d = INIT[g*WORD_W +: WORD_W];
            end else if (wr_en && (wr_word == WSEL_W'(g))) begin
                word_d = word_q & wr_data;
            end
        end

        // Fuse state: no reset, only the manufacture step reloads it.
        always_ff @(posedge clk) begin
            word_q <= word_d;
        end

        assign bits[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
    import otp_pkg::*;
(
    input  logic     init,
    input  logic     prog_en,
    input  otp_sel_e prog_sel,
    input  logic     lock_req,
    input  logic     locked,
    output logic     user_wr_en,
    output logic     lock_set,
    output verdict_t verdict
);

    logic any_cmd;
    logic refused;

    always_comb begin
        any_cmd    = 1'b0;
        refused    = 1'b0;
        user_wr_en = 1'b0;
        lock_set   = 1'b0;
        if (!init) begin
            // The program is judged against the lock as it stands now.
            if (prog_en) begin
                any_cmd = 1'b1;
                if (prog_sel == SEL_USER && !locked) begin
                    user_wr_en = 1'b1;
                end else begin
                    refused = 1'b1;
                end
            end
            if (lock_req) begin
                any_cmd = 1'b1;
                if (!locked) begin
                    lock_set = 1'b1;
                end else begin
                    refused = 1'b1;
                end
            end
        end
        verdict.accept = any_cmd && !refused;
        verdict.refuse = refused;
    end

endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WORD_W*WORDS-1:0] factory_bits,
    input  logic [WORD_W*WORDS-1:0] user_bits,
    input  logic                    locked,
    output logic [WORD_W-1:0]       word
);

    localparam int STATUS_ADDR = 2 * WORDS;

    always_comb begin
        word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                word = factory_bits[i*WORD_W +: WORD_W];
            end
            if (addr == ADDR_W'(WORDS + i)) begin
                word = user_bits[i*WORD_W +: WORD_W];
            end
        end
        if (addr == ADDR_W'(STATUS_ADDR)) begin
            // bit 0: factory register always fixed, bit 1: user lock
            word = WORD_W'({locked, 1'b1});
        end
    end

endmodule

// File: rtl/otp_prot_regs.sv
module otp_prot_regs
    import otp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 4,
    parameter logic [WORD_W*WORDS-1:0] FACTORY_ID = 64'h3C96_0F5A_D271_84EB,
    localparam int REG_W  = WORD_W * WORDS,
    localparam int ADDR_W = $clog2(2 * WORDS + 1),
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mfg_init,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              prog_en,
    input  logic              prog_sel,
    input  logic [WSEL_W-1:0] prog_word,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              lock_req,
    output logic              prog_done,
    output logic              prot_err
);

    typedef struct packed {
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
        logic              done;
        logic              err;
    } port_t;

    port_t port_d, port_q;
    logic  lock_d, lock_q;

    logic [REG_W-1:0]  factory_bits;
    logic [REG_W-1:0]  user_bits;
    logic              user_locked;
    logic              user_wr_en;
    logic              lock_set;
    verdict_t          verdict;
    logic [WORD_W-1:0] rd_word;

    assign user_locked = lock_q;

    otp_access_ctrl u_ctrl (
        .init       (mfg_init),
        .prog_en    (prog_en),
        .prog_sel   (otp_sel_e'(prog_sel)),
        .lock_req   (lock_req),
        .locked     (lock_q),
        .user_wr_en (user_wr_en),
        .lock_set   (lock_set),
        .verdict    (verdict)
    );

    otp_word_bank #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .INIT   (FACTORY_ID)
    ) u_factory (
        .clk     (clk),
        .init    (mfg_init),
        .wr_en   (1'b0),
        .wr_word (prog_word),
        .wr_data (prog_data),
        .bits    (factory_bits)
    );

    otp_word_bank #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .INIT   ({REG_W{1'b1}})
    ) u_user (
        .clk     (clk),
        .init    (mfg_init),
        .wr_en   (user_wr_en),
        .wr_word (prog_word),
        .wr_data (prog_data),
        .bits    (user_bits)
    );

    otp_read_mux #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .addr         (rd_addr),
        .factory_bits (factory_bits),
        .user_bits    (user_bits),
        .locked       (lock_q),
        .word         (rd_word)
    );

    always_comb begin
        port_d          = port_q;
        port_d.rd_valid = rd_en;
        if (rd_en) begin
            port_d.rd_data = rd_word;
        end
        port_d.done = verdict.accept;
        port_d.err  = verdict.refuse;

        lock_d = lock_q;
        if (mfg_init) begin
            lock_d = 1'b0;
        end else if (lock_set) begin
            lock_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    // The lock fuse ignores rst_n.
    always_ff @(posedge clk) begin
        lock_q <= lock_d;
    end

    assign rd_data   = port_q.rd_data;
    assign rd_valid  = port_q.rd_valid;
    assign prog_done = port_q.done;
    assign prot_err  = port_q.err;

endmodule

// File: rtl/otp_prot_regs_chk.sv
module otp_prot_regs_chk #(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mfg_init,
    input logic             rd_en,
    input logic             prog_en,
    input logic             prog_sel,
    input logic             rd_valid,
    input logic             prog_done,
    input logic             prot_err,
    input logic [REG_W-1:0] factory_bits,
    input logic [REG_W-1:0] user_bits,
    input logic             user_locked
);

    assert_factory_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mfg_init |=> $stable(factory_bits));

    assert_factory_prog_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !prog_sel && !mfg_init) |=> prot_err);

    assert_user_one_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mfg_init |=> ((user_bits & ~$past(user_bits)) == '0));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (user_locked && !mfg_init) |=> user_locked);

    assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (user_locked && !mfg_init) |=> $stable(user_bits));

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_done && prot_err));

endmodule

bind otp_prot_regs otp_prot_regs_chk #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mfg_init     (mfg_init),
    .rd_en        (rd_en),
    .prog_en      (prog_en),
    .prog_sel     (prog_sel),
    .rd_valid     (rd_valid),
    .prog_done    (prog_done),
    .prot_err     (prot_err),
    .factory_bits (factory_bits),
    .user_bits    (user_bits),
    .user_locked  (user_locked)
);

// File: tb/tb_otp_prot_regs.sv
module tb_otp_prot_regs;

    localparam logic [63:0] ID = 64'h3C96_0F5A_D271_84EB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mfg_init = 1'b1;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        prog_en = 1'b0;
    logic        prog_sel = 1'b0;
    logic [1:0]  prog_word = '0;
    logic [15:0] prog_data = '0;
    logic        lock_req = 1'b0;
    logic        prog_done;
    logic        prot_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model of the fuse state.
    logic [63:0] fac_m = ID;
    logic [63:0] usr_m = '1;
    logic        lock_m = 1'b0;

    logic [15:0] exp_data[$];
    string       exp_req[$];

    always #10ns clk = ~clk;

    otp_prot_regs #(.FACTORY_ID(ID)) dut (
        .clk(clk), .rst_n(rst_n), .mfg_init(mfg_init),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .prog_en(prog_en), .prog_sel(prog_sel), .prog_word(prog_word),
        .prog_data(prog_data), .lock_req(lock_req),
        .prog_done(prog_done), .prot_err(prot_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(logic [3:0] a);
        if (a < 4)  return fac_m[a*16 +: 16];
        if (a < 8)  return usr_m[(a-4)*16 +: 16];
        if (a == 8) return {14'b0, lock_m, 1'b1};
        return 16'h0000;
    endfunction

    // Monitor: pops the scoreboard whenever the design presents a read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_data.size() == 0) begin
                check("R9 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                automatic logic [15:0] e = exp_data.pop_front();
                automatic string r = exp_req.pop_front();
                check(r, {16'h0, rd_data}, {16'h0, e});
            end
        end
    end

    task automatic do_read(logic [3:0] a, string req);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        exp_data.push_back(model_word(a));
        exp_req.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < 9; a++) do_read(4'(a), req);
        repeat (2) @(negedge clk);
        check({req, " scoreboard drained"}, exp_data.size(), 0);
    endtask

    task automatic do_cmd(logic pe, logic sel, logic [1:0] w, logic [15:0] d,
                          logic lk, string req);
        logic refuse;
        logic any;
        refuse = 1'b0;
        any    = pe | lk;
        if (pe) begin
            if (sel && !lock_m) usr_m[w*16 +: 16] = usr_m[w*16 +: 16] & d;
            else refuse = 1'b1;
        end
        if (lk) begin
            if (!lock_m) lock_m = 1'b1;
            else refuse = 1'b1;
        end
        @(negedge clk);
        prog_en = pe; prog_sel = sel; prog_word = w; prog_data = d; lock_req = lk;
        @(negedge clk);
        prog_en = 1'b0; lock_req = 1'b0;
        check({req, " prog_done"}, prog_done, any && !refuse);
        check({req, " prot_err"}, prot_err, refuse);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mfg_init = 1'b0;
        @(negedge clk);
        check("R9 reset rd_valid", rd_valid, 0);
        check("R9 reset rd_data", rd_data, 0);
        check("R9 reset prog_done", prog_done, 0);
        check("R9 reset prot_err", prot_err, 0);
        rst_n = 1'b1;

        read_all("R1 R3 R5 initial contents");
        do_read(4'd12, "R9 unmapped address");
        repeat (2) @(negedge clk);
        check("R9 rd_data holds", rd_data, 0);

        do_cmd(1, 0, 2'd2, 16'h0000, 0, "R2 factory program");
        do_read(4'd2, "R2 factory word unchanged");

        do_cmd(1, 1, 2'd1, 16'hA5C3, 0, "R4 user program");
        do_read(4'd5, "R4 stored value");
        do_cmd(1, 1, 2'd1, 16'hFF0F, 0, "R4 second program AND");
        do_read(4'd5, "R4 AND result");
        do_cmd(1, 1, 2'd3, 16'h0000, 0, "R4 clear word");
        read_all("R4 neighbours untouched");

        do_cmd(0, 0, 2'd0, 16'h0000, 1, "R5 lock");
        do_read(4'd8, "R5 status after lock");
        do_cmd(1, 1, 2'd0, 16'h0000, 0, "R6 program after lock");
        do_cmd(0, 0, 2'd0, 16'h0000, 1, "R6 lock again");
        read_all("R6 frozen contents");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_all("R7 survives rst_n");

        @(negedge clk);
        mfg_init = 1'b1; prog_en = 1'b1; prog_sel = 1'b1; prog_word = 2'd0; prog_data = 16'h0;
        @(negedge clk);
        mfg_init = 1'b0; prog_en = 1'b0;
        fac_m = ID; usr_m = '1; lock_m = 1'b0;
        check("R7 command ignored during init done", prog_done, 0);
        check("R7 command ignored during init err", prot_err, 0);
        read_all("R7 after mfg_init");

        do_cmd(1, 1, 2'd0, 16'h1234, 1, "R8 program with lock");
        read_all("R8 contents after same-cycle lock");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule